// File: doc/BRIEF.md
# Underflow Interrupt Decimation Counter

This block sits beside a periodic timer and thins its stream of underflow strobes so that the interrupt line pulses only once for every n counted underflows, with n a 4-bit period programmed through a small write port. A count-mode input decides which strobes count. With the mode low, every underflow counts. With the mode high, only underflows that arrive together with an external qualifier count.

A short-start input makes the first interrupt of a fresh sequence come one counted underflow early (after n-1), and every later interrupt then follows after n more. A sequence starts fresh after reset and after any write that is allowed to reload the counter: a write while the timer is stopped, or any write in qualified mode. A write while the timer runs in all-underflow mode only changes the period. If such a write arrives in the same cycle as an underflow, the write is dropped and a sticky error flag is raised.

Top module: `uflow_irq_decimator`

## Requirements
- R1: After reset the interrupt and error outputs are 0, the period is 1 and the counter is cleared, so with count mode 0 and short start 0 the first underflow raises an interrupt.
- R2: With count mode 0, every cycle with `uflow_i` high is one counted event, and the interrupt fires on every n-th counted event.
- R3: With count mode 1, only cycles with both `uflow_i` and `qual_i` high are counted; an underflow with `qual_i` low leaves the count unchanged.
- R4: With short start 1, the first interrupt of a fresh sequence fires on the (n-1)-th counted event (on the 1st when n is 1), and later interrupts fire every n counted events.
- R5: An accepted write made while `tmr_run_i` is 0, or made with count mode 1, clears the count and restores the short first period; a counted event in that same cycle is discarded.
- R6: An accepted write with count mode 0 and `tmr_run_i` 1 changes the period without clearing the count; the next counted event that brings the count to at least the new period fires the interrupt.
- R7: A write in a cycle where count mode is 0, `tmr_run_i` is 1 and `uflow_i` is 1 is ignored, the underflow is still counted, and `wr_err_o` goes to 1 and stays at 1 until reset.
- R8: `irq_o` is a one-clock pulse registered on the clock edge that samples the final counted event; it is 0 in every cycle after an edge that samples no counted event.
- R9: A write of the value 0 is stored as period 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| uflow_i | input | 1 | Timer underflow strobe, one cycle per underflow |
| qual_i | input | 1 | Qualifier condition for counted underflows in mode 1 |
| mode_qual_i | input | 1 | Count mode: 0 all underflows, 1 qualified underflows only |
| short_start_i | input | 1 | 1 makes the first period of a fresh sequence n-1 |
| tmr_run_i | input | 1 | 1 while the timer is running |
| wr_en_i | input | 1 | Period write strobe |
| wr_data_i | input | 4 | Period value to write, legal 1 to 15 |
| irq_o | output | 1 | Interrupt pulse |
| wr_err_o | output | 1 | Sticky flag: a write collided with an underflow |

## Verification
The bench sweeps every period from 1 to 15 in both count modes and with short start off and on, predicting each interrupt position from the arithmetic of the counted-event index. A design that counted unqualified underflows would fire early in mode 1, one that ignored short start or applied it to every period would misplace pulses after the first, and one that stretched the pulse would show a high interrupt in the idle cycles between events. Further directed runs cover a mid-sequence reload in qualified mode, a running period change that must keep the count, a colliding write that must neither change the period nor clear the error flag afterwards, and a zero write that must behave as period 1.

// File: rtl/uicnt_pkg.sv
// Shared widths and helpers for the underflow interrupt decimator.
// Assumes: the period field is narrow enough that a counter of the same
// width plus one carry bit covers every comparison.
package uicnt_pkg;
    parameter int unsigned PER_W = 4;
    typedef logic [PER_W-1:0] per_t;

    // Clamp a written period value into the legal range (0 becomes 1).
    function automatic per_t clamp_period(input per_t v);
        return (v == '0) ? per_t'(1) : v;
    endfunction
endpackage

// File: rtl/uicnt_period_reg.sv
// Holds the programmed period and decides what each write does.
// A write colliding with an underflow while every underflow counts and the
// timer runs is dropped and flagged; an accepted write while stopped or in
// qualified mode asks the counter to restart its sequence.
// Assumes: all inputs are synchronous to clk.
module uicnt_period_reg
    import uicnt_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic wr_en_i,
    input  per_t wr_data_i,
    input  logic mode_qual_i,
    input  logic tmr_run_i,
    input  logic uflow_i,
    output per_t period_o,
    output logic reload_o,
    output logic err_o
);
    logic collide;
    logic accept;
    per_t period_q;
    logic err_q;

    // Classify the current write request.
    always_comb begin
        collide  = wr_en_i && !mode_qual_i && tmr_run_i && uflow_i;
        accept   = wr_en_i && !collide;
        reload_o = accept && (!tmr_run_i || mode_qual_i);
    end

    // Period register and sticky collision flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            period_q <= per_t'(1);
            err_q    <= 1'b0;
        end else begin
            if (accept) period_q <= clamp_period(wr_data_i);
            if (collide) err_q   <= 1'b1;
        end
    end

    assign period_o = period_q;
    assign err_o    = err_q;

    AST_COLLIDE_KEEPS_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
        collide |=> $stable(period_q)); // R7
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        err_q |=> err_q); // R7
    AST_PERIOD_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        period_q != '0); // R9
endmodule

// File: rtl/uicnt_div_core.sv
// Counts qualifying underflows and raises a one-clock interrupt when the
// count reaches the current target, reloading itself in the same cycle.
// The target is n, or n-1 (at least 1) for the first period of a fresh
// sequence when short start is selected.
// Assumes: reload_i wins over a counted event in the same cycle.
module uicnt_div_core
    import uicnt_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic uflow_i,
    input  logic qual_i,
    input  logic mode_qual_i,
    input  logic short_start_i,
    input  per_t period_i,
    input  logic reload_i,
    output logic irq_o
);
    localparam int unsigned CW = PER_W + 1;

    logic           ev;
    per_t           target;
    logic [CW-1:0]  next_cnt;
    logic           hit;
    per_t           cnt_q;
    logic           first_q;
    logic           irq_q;

    // Event qualification, target selection and terminal compare.
    always_comb begin
        ev = uflow_i && (mode_qual_i ? qual_i : 1'b1);
        if (first_q && short_start_i && (period_i > per_t'(1)))
            target = period_i - per_t'(1);
        else
            target = period_i;
        next_cnt = {1'b0, cnt_q} + CW'(1);
        hit = ev && !reload_i && (next_cnt >= {1'b0, target});
    end

    // Counter, first-period flag and registered interrupt pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            first_q <= 1'b1;
            irq_q   <= 1'b0;
        end else if (reload_i) begin
            cnt_q   <= '0;
            first_q <= 1'b1;
            irq_q   <= 1'b0;
        end else begin
            irq_q <= hit;
            if (hit) begin
                cnt_q   <= '0;
                first_q <= 1'b0;
            end else if (ev) begin
                cnt_q <= next_cnt[PER_W-1:0];
            end
        end
    end

    assign irq_o = irq_q;

    AST_IRQ_NEEDS_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
        !ev |=> !irq_q); // R8
    AST_UNQUALIFIED_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_qual_i && uflow_i && !qual_i && !reload_i) |=> $stable(cnt_q)); // R3
    AST_RELOAD_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        reload_i |=> (cnt_q == '0 && first_q && !irq_q)); // R5
    AST_FIRST_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
        irq_q |-> !first_q); // R4
endmodule

// File: rtl/uflow_irq_decimator.sv
// Top of the underflow interrupt decimator: a period register with write
// policy and a decimating counter that drives the interrupt pulse.
// Assumes: synchronous active-low reset; uflow_i is one cycle per underflow.
module uflow_irq_decimator
    import uicnt_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             uflow_i,
    input  logic             qual_i,
    input  logic             mode_qual_i,
    input  logic             short_start_i,
    input  logic             tmr_run_i,
    input  logic             wr_en_i,
    input  logic [PER_W-1:0] wr_data_i,
    output logic             irq_o,
    output logic             wr_err_o
);
    per_t period;
    logic reload;

    // Period storage and write policy.
    uicnt_period_reg u_per (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en_i     (wr_en_i),
        .wr_data_i   (wr_data_i),
        .mode_qual_i (mode_qual_i),
        .tmr_run_i   (tmr_run_i),
        .uflow_i     (uflow_i),
        .period_o    (period),
        .reload_o    (reload),
        .err_o       (wr_err_o)
    );

    // Decimating counter.
    uicnt_div_core u_core (
        .clk           (clk),
        .rst_n         (rst_n),
        .uflow_i       (uflow_i),
        .qual_i        (qual_i),
        .mode_qual_i   (mode_qual_i),
        .short_start_i (short_start_i),
        .period_i      (period),
        .reload_i      (reload),
        .irq_o         (irq_o)
    );

    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |=> (!irq_o && !wr_err_o)); // R1
endmodule

// File: tb/uflow_irq_decimator_tb_top.sv
module uflow_irq_decimator_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       uflow = 1'b0, qual = 1'b0, mode = 1'b0, sshort = 1'b0, run = 1'b0;
    logic       wr = 1'b0;
    logic [3:0] wdata = 4'd0;
    logic       irq, err;
    int         n_checks = 0, n_errors = 0;
    bit         done = 1'b0;

    always #2 clk = ~clk; // 250 MHz

    uflow_irq_decimator dut_i (
        .clk(clk), .rst_n(rst_n), .uflow_i(uflow), .qual_i(qual),
        .mode_qual_i(mode), .short_start_i(sshort), .tmr_run_i(run),
        .wr_en_i(wr), .wr_data_i(wdata), .irq_o(irq), .wr_err_o(err)
    );

    task automatic chk(input logic got, input logic exp, input string tag);
        n_checks++;
        if (got !== exp) begin
            n_errors++;
            $display("FAIL %s actual=%0b expected=%0b", tag, got, exp);
        end
    endtask

    // One clock: drive at negedge, sample 1 ns after the rising edge.
    task automatic step(input logic u, input logic q, input logic w, input logic [3:0] d);
        @(negedge clk);
        uflow = u; qual = q; wr = w; wdata = d;
        @(posedge clk);
        #1;
    endtask

    function automatic bit fires(input int k, input int n, input bit s);
        int t0;
        t0 = s ? ((n > 1) ? n - 1 : 1) : n;
        return (k == t0) || (k > t0 && ((k - t0) % n) == 0);
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_errors++;
            n_checks++;
            $display("FAIL R8 watchdog actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (3) step(0, 0, 0, 0);
        rst_n = 1'b1;
        chk(irq, 0, "R1 irq after reset");
        chk(err, 0, "R1 err after reset");
        run = 1'b1;
        step(1, 0, 0, 0);
        chk(irq, 1, "R1 default period 1 fires");
        step(0, 0, 0, 0);
        chk(irq, 0, "R8 pulse ends");

        // R2 / R4 / R8 sweep in all-underflow mode
        for (int s = 0; s < 2; s++) begin
            for (int n = 1; n <= 15; n++) begin
                mode = 1'b0; sshort = s[0]; run = 1'b0;
                step(0, 0, 1, 4'(n));
                chk(irq, 0, "R5 no irq on write");
                run = 1'b1;
                for (int k = 1; k <= 2 * n + 2; k++) begin
                    step(1, 0, 0, 0);
                    chk(irq, fires(k, n, s[0]), s ? "R4 short first mode0" : "R2 every nth");
                    step(0, 0, 0, 0);
                    chk(irq, 0, "R8 idle cycle");
                end
            end
        end

        // R3 / R4 sweep in qualified mode
        for (int s = 0; s < 2; s++) begin
            for (int n = 1; n <= 15; n++) begin
                mode = 1'b1; sshort = s[0]; run = 1'b0;
                step(0, 0, 1, 4'(n));
                run = 1'b1;
                for (int k = 1; k <= 2 * n + 2; k++) begin
                    step(1, 0, 0, 0);
                    chk(irq, 0, "R3 unqualified underflow");
                    step(0, 1, 0, 0);
                    chk(irq, 0, "R3 qualifier alone");
                    step(1, 1, 0, 0);
                    chk(irq, fires(k, n, s[0]), s ? "R4 short first mode1" : "R3 qualified nth");
                end
            end
        end

        // R5: running write in qualified mode restarts the sequence
        mode = 1'b1; sshort = 1'b0; run = 1'b0;
        step(0, 0, 1, 4'd5);
        run = 1'b1;
        repeat (3) step(1, 1, 0, 0);
        step(1, 1, 1, 4'd5);
        chk(irq, 0, "R5 event in reload cycle discarded");
        for (int k = 1; k <= 5; k++) begin
            step(1, 1, 0, 0);
            chk(irq, k == 5, "R5 restart after qualified write");
        end

        // R5: stopped write restores short first period
        mode = 1'b0; sshort = 1'b1; run = 1'b0;
        step(0, 0, 1, 4'd4);
        run = 1'b1;
        for (int k = 1; k <= 5; k++) begin
            step(1, 0, 0, 0);
            chk(irq, k == 3, "R5 R4 first after stopped write");
        end
        run = 1'b0;
        step(0, 0, 1, 4'd4);
        run = 1'b1;
        for (int k = 1; k <= 3; k++) begin
            step(1, 0, 0, 0);
            chk(irq, k == 3, "R5 short first restored");
        end

        // R6: running write in mode 0 keeps the count
        sshort = 1'b0; run = 1'b0;
        step(0, 0, 1, 4'd4);
        run = 1'b1;
        repeat (2) step(1, 0, 0, 0);
        step(0, 0, 1, 4'd6);
        for (int k = 3; k <= 7; k++) begin
            step(1, 0, 0, 0);
            chk(irq, k == 6, "R6 new period keeps count");
        end
        run = 1'b0;
        step(0, 0, 1, 4'd6);
        run = 1'b1;
        repeat (4) step(1, 0, 0, 0);
        step(0, 0, 1, 4'd2);
        step(1, 0, 0, 0);
        chk(irq, 1, "R6 lowered period fires at once");

        // R7: collision ignored, event counted, sticky error
        run = 1'b0;
        step(0, 0, 1, 4'd3);
        chk(err, 0, "R7 no error yet");
        run = 1'b1;
        step(1, 0, 0, 0);
        step(1, 0, 1, 4'd7);
        chk(err, 1, "R7 error raised");
        chk(irq, 0, "R7 second event no irq");
        step(1, 0, 0, 0);
        chk(irq, 1, "R7 period unchanged at 3");
        run = 1'b0;
        step(0, 0, 1, 4'd2);
        chk(err, 1, "R7 error sticky after good write");

        // R9: zero write acts as period 1
        run = 1'b0;
        step(0, 0, 1, 4'd0);
        run = 1'b1;
        for (int k = 0; k < 3; k++) begin
            step(1, 0, 0, 0);
            chk(irq, 1, "R9 zero write gives period 1");
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule